// File: doc/BRIEF.md
# Multilevel Priority Bus Arbiter

This block decides which of eight local masters owns a shared, pipelined system bus. Each master presents a 3-bit priority code, a lock input and receives a one-hot registered grant. A request at a more urgent level always beats a less urgent one. Masters that tie at the most urgent level are served in rotation, with a separate rotation pointer kept for each level.

Once a master owns the bus it keeps it for as long as its request code stays non-zero or its lock input stays high, so a packet in flight is never cut short. A system-wide stop input blocks every new grant while the current owner finishes, which freezes the bus on a packet boundary. A slice-level summary (any request, most urgent local level) and a slice grant input let several slices be chained into a larger distributed arbiter.

Top module: `prio_bus_arbiter`

## Requirements
- R1: Priority code 0 on a master means no request; codes 1 to 7 are requests with 7 the most urgent. When a new owner is chosen, it always comes from the most urgent level present.
- R2: The grant output is registered and carries at most one set bit (bit i = master i). A decision made from the inputs seen at one rising edge appears on `grant` right after that edge.
- R3: Among masters at the winning level, the chosen one is the first requester found scanning upward (with wrap from 7 to 0) from the master after the last winner at that level. Each level has its own pointer.
- R4: While the owner's lock input is high it keeps the grant, even with its request code at 0 and with more urgent requests present.
- R5: While the owner's request code is non-zero it keeps the grant, whatever other masters request.
- R6: While `sys_stop` is high no new grant is issued; the current owner keeps the bus until it releases, after which `grant` goes to 0.
- R7: `casc_req` is high exactly when some master has a non-zero code, and `casc_lvl` equals the most urgent code present (0 when none); both are combinational from the inputs.
- R8: While `casc_grant_in` is low no new grant is issued; an existing owner is not affected.
- R9: After reset `grant` is 0 and every level's rotation pointer points at master 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_lvl | input | 24 | Priority code per master, master i in bits [3i+2:3i] |
| hold | input | 8 | Lock input per master |
| sys_stop | input | 1 | Blocks new grants when high |
| casc_grant_in | input | 1 | Slice grant from the upper arbiter stage; low blocks new grants |
| grant | output | 8 | One-hot registered grant |
| casc_req | output | 1 | Some local master requests |
| casc_lvl | output | 3 | Most urgent local request code |

## Verification
The bench builds the block with its default of eight masters and 3-bit codes, so all seven request levels, their independent rotation pointers and the wrap from master 7 back to master 0 are all reachable. Directed sequences show level precedence, rotation order, lock retention, stop and slice-grant blocking; a long random phase with sticky requests and locks then compares grant and slice outputs against a behavioural model every clock.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int DEF_MASTERS = 8;
  localparam int DEF_LVL_W   = 3;
endpackage

// File: rtl/arb_rst_sync.sv
module arb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/arb_level_scan.sv
module arb_level_scan #(
  parameter int N_MST = arb_pkg::DEF_MASTERS,
  parameter int LVL_W = arb_pkg::DEF_LVL_W
) (
  input  logic [N_MST*LVL_W-1:0] req_lvl,
  output logic [LVL_W-1:0]       top_lvl,
  output logic [N_MST-1:0]       top_mask,
  output logic                   any_req
);
  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (req_lvl[i*LVL_W +: LVL_W] > top_lvl) top_lvl = req_lvl[i*LVL_W +: LVL_W];
    end
    for (int i = 0; i < N_MST; i++) begin
      top_mask[i] = (top_lvl != '0) && (req_lvl[i*LVL_W +: LVL_W] == top_lvl);
    end
    any_req = (top_lvl != '0);
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N_MST = arb_pkg::DEF_MASTERS,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] mask,
  input  logic [IDX_W-1:0] start,
  output logic             found,
  output logic [IDX_W-1:0] pick
);
  int cand;

  always_comb begin
    found = 1'b0;
    pick  = '0;
    cand  = 0;
    for (int k = 0; k < N_MST; k++) begin
      cand = (int'(start) + k) % N_MST;
      if (!found && mask[cand]) begin
        found = 1'b1;
        pick  = IDX_W'(cand);
      end
    end
  end
endmodule

// File: rtl/prio_bus_arbiter.sv
module prio_bus_arbiter #(
  parameter int N_MST = arb_pkg::DEF_MASTERS,
  parameter int LVL_W = arb_pkg::DEF_LVL_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_MST*LVL_W-1:0] req_lvl,
  input  logic [N_MST-1:0]       hold,
  input  logic                   sys_stop,
  input  logic                   casc_grant_in,
  output logic [N_MST-1:0]       grant,
  output logic                   casc_req,
  output logic [LVL_W-1:0]       casc_lvl
);
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;
  localparam int N_LVL = 1 << LVL_W;

  logic             rst_i_n;
  logic [LVL_W-1:0] top_lvl;
  logic [N_MST-1:0] top_mask;
  logic             any_req;
  logic             pick_found;
  logic [IDX_W-1:0] pick_idx;
  logic [IDX_W-1:0] pick_start;
  logic [IDX_W-1:0] ptr_q [N_LVL];
  logic [IDX_W-1:0] ptr_d;
  logic [N_LVL-1:0] ptr_en;
  logic [N_MST-1:0] grant_q, grant_d;
  logic             own_keep;
  logic             new_ok;

  arb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  arb_level_scan #(.N_MST(N_MST), .LVL_W(LVL_W)) u_scan (
    .req_lvl(req_lvl), .top_lvl(top_lvl), .top_mask(top_mask), .any_req(any_req)
  );

  assign pick_start = ptr_q[top_lvl];

  arb_rr_pick #(.N_MST(N_MST)) u_pick (
    .mask(top_mask), .start(pick_start), .found(pick_found), .pick(pick_idx)
  );

  // owner retention: request still present or lock held
  always_comb begin
    own_keep = 1'b0;
    for (int i = 0; i < N_MST; i++) begin
      own_keep |= grant_q[i] & ((req_lvl[i*LVL_W +: LVL_W] != '0) | hold[i]);
    end
  end

  assign new_ok = !own_keep && !sys_stop && casc_grant_in && any_req && pick_found;

  always_comb begin
    if (own_keep)    grant_d = grant_q;
    else if (new_ok) grant_d = N_MST'(1) << pick_idx;
    else             grant_d = '0;
  end

  assign ptr_d = (pick_idx == IDX_W'(N_MST - 1)) ? '0 : pick_idx + 1'b1;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) grant_q <= '0;
    else          grant_q <= grant_d;
  end

  genvar l;
  generate
    for (l = 0; l < N_LVL; l++) begin : g_lvl_ptr
      assign ptr_en[l] = new_ok && (top_lvl == LVL_W'(l));
      always_ff @(posedge clk or negedge rst_i_n) begin
        if (!rst_i_n)       ptr_q[l] <= '0;
        else if (ptr_en[l]) ptr_q[l] <= ptr_d;
      end
    end
  endgenerate

  assign grant    = grant_q;
  assign casc_req = any_req;
  assign casc_lvl = top_lvl;
endmodule

// File: rtl/prio_bus_arbiter_chk.sv
module prio_bus_arbiter_chk #(
  parameter int N_MST = arb_pkg::DEF_MASTERS,
  parameter int LVL_W = arb_pkg::DEF_LVL_W
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [N_MST*LVL_W-1:0] req_lvl,
  input logic [N_MST-1:0]       hold,
  input logic                   sys_stop,
  input logic                   casc_grant_in,
  input logic [N_MST-1:0]       grant,
  input logic                   casc_req,
  input logic [LVL_W-1:0]       casc_lvl
);
  logic [N_MST-1:0] act;
  logic [N_MST-1:0] stay;

  always_comb begin
    for (int i = 0; i < N_MST; i++) begin
      act[i]  = (req_lvl[i*LVL_W +: LVL_W] != '0);
      stay[i] = act[i] | hold[i];
    end
  end

  a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));

  a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & hold)) |=> (grant == $past(grant)));

  a_r5_no_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant & act)) |=> (grant == $past(grant)));

  a_r6_stop_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_stop && !(|(grant & stay))) |=> (grant == '0));

  a_r8_casc_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!casc_grant_in && !(|(grant & stay))) |=> (grant == '0));

  always_comb begin
    if (rst_n) begin
      a_r7_casc_req: assert (casc_req == (|act));
      a_r7_casc_lvl: assert ((casc_lvl != '0) == casc_req);
    end
  end
endmodule

bind prio_bus_arbiter prio_bus_arbiter_chk #(.N_MST(N_MST), .LVL_W(LVL_W)) u_chk (.*);

// File: tb/prio_bus_arbiter_test.sv
`timescale 1ns/1ps
module prio_bus_arbiter_test;
  localparam int N = 8;
  localparam int LW = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N*LW-1:0] req_lvl = '0;
  logic [N-1:0]    hold = '0;
  logic            sys_stop = 1'b0;
  logic            casc_grant_in = 1'b1;
  logic [N-1:0]    grant;
  logic            casc_req;
  logic [LW-1:0]   casc_lvl;

  int tests = 0;
  int fails = 0;
  int owner = -1;
  int ptr[8];
  bit done = 0;

  prio_bus_arbiter uut (.*);

  always #2 clk = ~clk;

  function automatic int lvl_of(int m);
    return int'(req_lvl[m*LW +: LW]);
  endfunction

  task automatic set_lvl(int m, int v);
    req_lvl[m*LW +: LW] = LW'(v);
  endtask

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called right after a falling edge with inputs already driven
  task automatic step(string tag);
    int top;
    bit keep;
    top = 0;
    #1;
    for (int m = 0; m < N; m++) if (lvl_of(m) > top) top = lvl_of(m);
    chk("R7 casc_req", int'(casc_req), int'(top != 0));
    chk("R7 casc_lvl", int'(casc_lvl), top);
    keep = (owner >= 0) && ((lvl_of(owner) != 0) || hold[owner]);
    if (!keep) begin
      owner = -1;
      if (!sys_stop && casc_grant_in && top != 0) begin
        for (int k = 0; k < N; k++) begin
          int c;
          c = (ptr[top] + k) % N;
          if (owner < 0 && lvl_of(c) == top) owner = c;
        end
        ptr[top] = (owner + 1) % N;
      end
    end
    @(posedge clk);
    #1;
    chk(tag, int'(grant), (owner < 0) ? 0 : (1 << owner));
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < 8; l++) ptr[l] = 0;
    repeat (3) @(negedge clk);
    chk("R9 grant in reset", int'(grant), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    step("R9 idle after reset");

    // R1 level precedence
    set_lvl(2, 3); set_lvl(5, 6);
    step("R1 higher level wins");
    set_lvl(5, 0);
    step("R1 lower level after release");
    set_lvl(2, 0);
    step("R1 idle");

    // R3 rotation at one level, with wrap
    set_lvl(1, 4); set_lvl(3, 4); set_lvl(6, 4);
    step("R3 first at level 4");
    for (int r = 0; r < 4; r++) begin
      int w;
      w = owner;
      set_lvl(w, 0);
      step("R3 release");
      set_lvl(w, 4);
      step("R3 rotation order");
    end
    set_lvl(1, 0); set_lvl(3, 0); set_lvl(6, 0);
    step("R3 drain");
    step("R3 idle");

    // R4 lock retention
    set_lvl(0, 1); hold[0] = 1'b1;
    step("R4 grant to locker");
    set_lvl(0, 0); set_lvl(7, 7);
    step("R4 lock keeps grant");
    step("R4 lock keeps grant again");
    hold[0] = 1'b0;
    step("R4 release to level 7");

    // R5 no cut by more urgent request
    set_lvl(4, 7);
    step("R5 owner kept");
    set_lvl(7, 0);
    step("R5 handover");
    set_lvl(4, 0);
    step("R5 idle");

    // R6 system stop
    sys_stop = 1'b1; set_lvl(3, 2);
    step("R6 no grant while stopped");
    sys_stop = 1'b0;
    step("R6 grant after stop");
    sys_stop = 1'b1; set_lvl(5, 5);
    step("R6 owner finishes under stop");
    set_lvl(3, 0);
    step("R6 bus frozen after release");
    sys_stop = 1'b0;
    step("R6 resume");
    set_lvl(5, 0);
    step("R6 idle");

    // R8 cascade gate
    casc_grant_in = 1'b0; set_lvl(6, 3);
    step("R8 no grant without slice grant");
    casc_grant_in = 1'b1;
    step("R8 grant with slice grant");
    casc_grant_in = 1'b0;
    step("R8 owner unaffected");
    set_lvl(6, 0);
    step("R8 idle");
    casc_grant_in = 1'b1;

    // R2 random traffic against the model
    for (int t = 0; t < 4000; t++) begin
      for (int m = 0; m < N; m++) begin
        if ($urandom_range(0, 5) == 0) set_lvl(m, ($urandom_range(0, 1) == 0) ? 0 : $urandom_range(1, 7));
        if ($urandom_range(0, 15) == 0) hold[m] = ~hold[m];
      end
      sys_stop      = ($urandom_range(0, 19) == 0);
      casc_grant_in = ($urandom_range(0, 9) != 0);
      step("R2 random grant");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule